// File: doc/BRIEF.md
# Sixteen-bit compare timer with forced compare strobes

The block is a 16-bit up-counter with three output-compare channels. Each channel holds a 16-bit compare value and drives one waveform pin. A CPU reaches the counter and the compare values over an 8-bit bus, one byte address for each half. A single shared high-byte holding register makes every 16-bit transfer atomic. The counter can stop, advance on every system clock, or advance on a chosen edge of an external pin after synchronisation. In the clear-on-match mode, channel A sets the counter period.

Software can make a channel act as though its compare had matched by writing a strobe bit. A forced compare changes the pin according to the channel's output mode. It raises no event and leaves the counter untouched. Any CPU write to the counter arms a one-shot mask that suppresses compare matches on all channels for the next counter tick.

The mask is a two-state machine. State `ST_ARMED` lets matches through. A counter write takes it to `ST_MASKED` on the transition named *write-mask*. In `ST_MASKED` the next tick is consumed without a match, and the transition *tick-release* returns it to `ST_ARMED`. A further write while in `ST_MASKED` keeps it there (*write-hold*). With no write and no tick, each state holds.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset the counter, the holding register and all compare values are zero, every pin is low and no compare event is raised.
- R2: Writing a high-byte address (odd addresses 1, 3, 5, 7) loads only the holding register. Writing a low-byte address (0 counter, 2/4/6 compare A/B/C) loads the whole 16-bit target in one cycle, with the holding register as the high byte.
- R3: Reading counter address 0 returns the counter's low byte and copies the counter's high byte into the holding register. Reading address 1 returns the holding register. Compare registers read back their bytes directly.
- R4: `clk_src` 00 stops the counter and 01 advances it by one on every clock. With `wave_mode` 00 (free-running) the counter wraps from 0xFFFF to 0x0000.
- R5: With `clk_src` 10 the counter advances on rising edges of `ext_clk_pin`, and with 11 on falling edges. Each edge passes through a two-flop synchroniser and an edge detector, so the counter changes on the third clock edge after the pin changes. The opposite edge does not advance the counter.
- R6: A match occurs on a tick while the counter equals a channel's compare value and the mask is armed. The pin action is applied at that edge, and `cmp_event` for the channel pulses high for exactly the following cycle.
- R7: Each channel's 2-bit output mode selects the pin action on a match or force: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low, 11 drives it high.
- R8: With `wave_mode` 01, a match on channel A loads zero into the counter in place of the increment.
- R9: Any counter low-byte write masks compare matches on every channel, including the clear of R8, for the next tick only.
- R10: Writing address 8 with bit 7, 6 or 5 set forces channel A, B or C in free-running or clear-on-match mode. The pin action is applied at that edge with no event and no change to the counter.
- R11: With `wave_mode` 10 or 11, force strobes are ignored and matches raise events without moving the pins. Address 8 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 2 | 00 free-running, 01 clear on A match, 1x PWM-style (pins held) |
| clk_src | input | 2 | 00 stop, 01 every clock, 10 pin rising, 11 pin falling |
| com_mode | input | 6 | Output mode per channel, A in [1:0], B in [3:2], C in [5:4] |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects of R3 apply) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| oc_pin | output | 3 | Compare output pins, bit 0 = A |
| cmp_event | output | 3 | One-cycle compare match events, bit 0 = A |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that reset starts every register. They also assume the external pin is a level that stays put for at least a few clocks. The bench meets these assumptions by driving every input on the falling clock edge. It issues only one bus strobe at a time and holds `ext_clk_pin` steady for several cycles around each edge. Configuration inputs change only while the counter is stopped or has a known number of pending ticks, so each tick and its match can be counted exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        WM_FREE  = 2'b00,
        WM_CLEAR = 2'b01,
        WM_PWM0  = 2'b10,
        WM_PWM1  = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        COM_HOLD   = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_LOW    = 2'b10,
        COM_HIGH   = 2'b11
    } com_e;

    typedef enum logic [1:0] {
        SRC_STOP = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_RISE = 2'b10,
        SRC_FALL = 2'b11
    } clk_src_e;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_MASKED = 1'b1
    } mask_state_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic pulse
);
    logic sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        if (fall_sel) pulse = prev_q & ~sync2_q;
        else          pulse = sync2_q & ~prev_q;
    end
endmodule

// File: rtl/tmr_mask_fsm.sv
module tmr_mask_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_wr,
    input  logic tick,
    output logic cmp_ok
);
    mask_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  if (cnt_wr) state_d = ST_MASKED;
            ST_MASKED: begin
                if (cnt_wr)    state_d = ST_MASKED;
                else if (tick) state_d = ST_ARMED;
            end
            default:   state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        cmp_ok = (state_q == ST_ARMED);
    end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_ok,
    input  logic             pwm,
    input  logic             force_stb,
    input  logic [1:0]       com,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ocr,
    output logic             match,
    output logic             oc,
    output logic             evt
);
    logic oc_q, evt_q, hit, act, oc_d;

    assign match = (cnt == ocr);
    assign hit   = tick & cmp_ok & match;
    assign act   = ~pwm & (force_stb | hit);

    always_comb begin
        oc_d = oc_q;
        if (act) begin
            unique case (com_e'(com))
                COM_HOLD:   oc_d = oc_q;
                COM_TOGGLE: oc_d = ~oc_q;
                COM_LOW:    oc_d = 1'b0;
                COM_HIGH:   oc_d = 1'b1;
                default:    oc_d = oc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_q  <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            oc_q  <= oc_d;
            evt_q <= hit;
        end
    end

    assign oc  = oc_q;
    assign evt = evt_q;

    // R10: a strobe alone never yields an event
    assert_force_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !tick) |=> !evt_q);
    // R11: pins frozen in PWM-style modes
    assert_pwm_holds_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |=> $stable(oc_q));
    // R6: events only follow a tick
    assert_event_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(tick));
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_CH   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wave_mode,
    input  logic [1:0]          clk_src,
    input  logic [2*N_CH-1:0]   com_mode,
    input  logic                ext_clk_pin,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_CH-1:0]     oc_pin,
    output logic [N_CH-1:0]     cmp_event
);
    localparam int CNT_W      = 2 * DATA_W;
    localparam int FORCE_ADDR = 2 + 2 * N_CH;

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hold_q;
    logic [CNT_W-1:0]  ocr_q [N_CH];
    logic [N_CH-1:0]   ch_match;
    logic [N_CH-1:0]   force_stb;
    logic              ext_pulse, tick_raw, tick_eff, cmp_ok, pwm;
    logic              cnt_lo_wr, cnt_lo_rd, hi_wr, force_wr, ctc_clear;

    assign cnt_lo_wr = bus_wr && (bus_addr == ADDR_W'(0));
    assign cnt_lo_rd = bus_rd && (bus_addr == ADDR_W'(0));
    assign hi_wr     = bus_wr && bus_addr[0] && (bus_addr < ADDR_W'(FORCE_ADDR));
    assign force_wr  = bus_wr && (bus_addr == ADDR_W'(FORCE_ADDR));
    assign pwm       = wave_mode[1];

    tmr_edge_sync u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_clk_pin),
        .fall_sel (clk_src[0]),
        .pulse    (ext_pulse)
    );

    always_comb begin
        unique case (clk_src_e'(clk_src))
            SRC_STOP: tick_raw = 1'b0;
            SRC_SYS:  tick_raw = 1'b1;
            SRC_RISE: tick_raw = ext_pulse;
            SRC_FALL: tick_raw = ext_pulse;
            default:  tick_raw = 1'b0;
        endcase
    end
    assign tick_eff = tick_raw & ~cnt_lo_wr;

    tmr_mask_fsm u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_wr (cnt_lo_wr),
        .tick   (tick_eff),
        .cmp_ok (cmp_ok)
    );

    assign ctc_clear = (wave_mode == WM_CLEAR) && cmp_ok && ch_match[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hi_wr) begin
            hold_q <= bus_wdata;
        end else if (cnt_lo_rd) begin
            hold_q <= cnt_q[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_lo_wr) begin
            cnt_q <= {hold_q, bus_wdata};
        end else if (tick_eff) begin
            if (ctc_clear) cnt_q <= '0;
            else           cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 + 2 * i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ocr_q[i] <= '0;
            end else if (bus_wr && (bus_addr == LO_ADDR)) begin
                ocr_q[i] <= {hold_q, bus_wdata};
            end
        end

        assign force_stb[i] = force_wr & bus_wdata[DATA_W-1-i];

        tmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_eff),
            .cmp_ok    (cmp_ok),
            .pwm       (pwm),
            .force_stb (force_stb[i]),
            .com       (com_mode[2*i+1:2*i]),
            .cnt       (cnt_q),
            .ocr       (ocr_q[i]),
            .match     (ch_match[i]),
            .oc        (oc_pin[i]),
            .evt       (cmp_event[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0)) bus_rdata = cnt_q[DATA_W-1:0];
        if (bus_addr == ADDR_W'(1)) bus_rdata = hold_q;
        for (int k = 0; k < N_CH; k++) begin
            if (bus_addr == ADDR_W'(2 + 2 * k)) bus_rdata = ocr_q[k][DATA_W-1:0];
            if (bus_addr == ADDR_W'(3 + 2 * k)) bus_rdata = ocr_q[k][CNT_W-1:DATA_W];
        end
    end

    // R9: a tick taken while masked produces no event on any channel
    assert_masked_tick_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_eff && !cmp_ok) |=> (cmp_event == '0));
    // R8: armed A match in clear mode returns the counter to zero
    assert_ctc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_eff && cmp_ok && (wave_mode == 2'b01) && ch_match[0]) |=> (cnt_q == '0));
    // R10: a force strobe leaves the counter alone
    assert_force_keeps_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && !tick_eff) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: tb/tmr_cmp_top_bench.sv
module tmr_cmp_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wave_mode = 2'b00;
    logic [1:0] clk_src = 2'b00;
    logic [5:0] com_mode = 6'b0;
    logic       ext_clk_pin = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] oc_pin;
    logic [2:0] cmp_event;

    int n_checks = 0;
    int n_fail = 0;
    int ev_cnt [3] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    tmr_cmp_top u_tmr_cmp_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .wave_mode   (wave_mode),
        .clk_src     (clk_src),
        .com_mode    (com_mode),
        .ext_clk_pin (ext_clk_pin),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .oc_pin      (oc_pin),
        .cmp_event   (cmp_event)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) if (cmp_event[i]) ev_cnt[i]++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        do_rd(lo, l);
        do_rd(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        do_wr(lo + 4'd1, v[15:8]);
        do_wr(lo, v[7:0]);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        clk_src = 2'b01;
        repeat (n) @(posedge clk);
        @(negedge clk);
        clk_src = 2'b00;
        #1;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 pins low", oc_pin, 3'b000);
        chk("R1 no events", cmp_event, 3'b000);
        rd16(4'd0, v); chk("R1 counter zero", v, 16'h0000);
        rd16(4'd4, v); chk("R1 compare B zero", v, 16'h0000);
    endtask

    task automatic t_bytes;
        logic [15:0] v;
        wr16(4'd0, 16'h1234);
        rd16(4'd0, v); chk("R2 counter byte write", v, 16'h1234);
        do_wr(4'd1, 8'hAB);
        rd16(4'd0, v); chk("R2 high write alone ignored", v, 16'h1234);
        wr16(4'd2, 16'h5678);
        rd16(4'd2, v); chk("R2/R3 compare A readback", v, 16'h5678);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr16(4'd0, 16'hFFFE);
        run_ticks(3);
        rd16(4'd0, v); chk("R4 wrap past 0xFFFF", v, 16'h0001);
    endtask

    task automatic t_ext_rise;
        logic [15:0] v;
        wr16(4'd0, 16'h01FF);
        @(negedge clk); clk_src = 2'b10;
        @(negedge clk); ext_clk_pin = 1'b1;
        repeat (2) @(posedge clk);
        rd16(4'd0, v); chk("R3/R5 atomic read across pin tick", v, 16'h01FF);
        rd16(4'd0, v); chk("R5 rising edge counted", v, 16'h0200);
    endtask

    task automatic t_ext_fall;
        logic [15:0] v;
        @(negedge clk); clk_src = 2'b11;
        @(negedge clk); ext_clk_pin = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rd16(4'd0, v); chk("R5 falling edge counted", v, 16'h0201);
        @(negedge clk); ext_clk_pin = 1'b1;
        repeat (4) @(posedge clk);
        rd16(4'd0, v); chk("R5 rising edge ignored in falling mode", v, 16'h0201);
        @(negedge clk); clk_src = 2'b00;
    endtask

    task automatic t_match;
        int e0 [3];
        com_mode = {2'b10, 2'b11, 2'b01};
        wr16(4'd2, 16'h0020);
        wr16(4'd4, 16'h0020);
        wr16(4'd6, 16'h0020);
        wr16(4'd0, 16'h001E);
        e0 = ev_cnt;
        run_ticks(2);
        chk("R6 no match before equality", ev_cnt[0] - e0[0], 0);
        run_ticks(1);
        chk("R7 toggle/high/low actions", oc_pin, 3'b011);
        chk("R6 event A", ev_cnt[0] - e0[0], 1);
        chk("R6 event C", ev_cnt[2] - e0[2], 1);
    endtask

    task automatic t_block;
        logic [15:0] v;
        int e0 [3];
        e0 = ev_cnt;
        wr16(4'd0, 16'h0020);
        run_ticks(1);
        chk("R9 masked tick pins held", oc_pin, 3'b011);
        chk("R9 masked tick no events", (ev_cnt[0] - e0[0]) + (ev_cnt[1] - e0[1]) + (ev_cnt[2] - e0[2]), 0);
        rd16(4'd0, v); chk("R9 masked tick still counts", v, 16'h0021);
        wr16(4'd0, 16'h001F);
        run_ticks(2);
        chk("R9 mask lasts one tick only", oc_pin, 3'b010);
        chk("R9 event after release", ev_cnt[1] - e0[1], 1);
    endtask

    task automatic t_force;
        logic [15:0] v0, v1;
        logic [7:0] d;
        int e0 [3];
        e0 = ev_cnt;
        rd16(4'd0, v0);
        com_mode = {2'b11, 2'b00, 2'b01};
        do_wr(4'd8, 8'h20);
        chk("R10 force C high", oc_pin, 3'b110);
        com_mode = {2'b10, 2'b00, 2'b01};
        do_wr(4'd8, 8'h20);
        chk("R10 force C low", oc_pin, 3'b010);
        do_wr(4'd8, 8'hC0);
        chk("R7/R10 force A toggle, B hold", oc_pin, 3'b011);
        chk("R10 force raises no event", (ev_cnt[0] - e0[0]) + (ev_cnt[1] - e0[1]) + (ev_cnt[2] - e0[2]), 0);
        rd16(4'd0, v1); chk("R10 force keeps counter", v1, v0);
        do_rd(4'd8, d); chk("R11 strobe reads zero", d, 8'h00);
    endtask

    task automatic t_ctc;
        logic [15:0] v;
        int e0 [3];
        @(negedge clk); wave_mode = 2'b01;
        wr16(4'd2, 16'h0005);
        wr16(4'd0, 16'h0003);
        e0 = ev_cnt;
        run_ticks(3);
        rd16(4'd0, v); chk("R8 clear on A match", v, 16'h0000);
        chk("R8 pin A toggled on clear", oc_pin, 3'b010);
        chk("R8 event A on clear", ev_cnt[0] - e0[0], 1);
        wr16(4'd0, 16'h0005);
        do_wr(4'd8, 8'h80);
        chk("R10 force A in clear mode", oc_pin, 3'b011);
        rd16(4'd0, v); chk("R10 force does not clear", v, 16'h0005);
        run_ticks(1);
        rd16(4'd0, v); chk("R9 masked tick skips clear", v, 16'h0006);
        chk("R9 masked tick no event A", ev_cnt[0] - e0[0], 1);
    endtask

    task automatic t_pwm;
        logic [15:0] v;
        logic [7:0] d;
        int e0 [3];
        @(negedge clk); wave_mode = 2'b10;
        do_wr(4'd8, 8'h80);
        chk("R11 force ignored in PWM", oc_pin, 3'b011);
        wr16(4'd0, 16'h0004);
        e0 = ev_cnt;
        run_ticks(2);
        chk("R11 match leaves pin", oc_pin, 3'b011);
        chk("R11 match still raises event", ev_cnt[0] - e0[0], 1);
        rd16(4'd0, v); chk("R11 counter free-runs", v, 16'h0006);
        do_rd(4'd8, d); chk("R11 strobe reads zero in PWM", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_wrap();
        t_ext_rise();
        t_ext_fall();
        t_match();
        t_block();
        t_force();
        t_ctc();
        t_pwm();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule